// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a directory entry and then, for a small page, a table entry from memory. A request carries the linear address and two attribute bits: whether the access is a write, and whether it comes from user mode. At each level the walker checks that the entry is present and that the access has the rights to use it. It sets the accessed flag, and on a write to a small page the dirty flag, by writing the changed entry back to memory. The response is either a physical address or a fault with a small cause code. The linear address of the most recent fault stays visible on a dedicated output.

A directory entry with its large-page flag set maps a whole 4 MB region, but only while large pages are enabled. In that case the walk ends after one level. When paging is off, the linear address is passed through unchanged and memory is not touched. The walker holds one translation at a time.

Translation requests and responses use valid/ready handshakes. A transfer happens on any rising edge where both valid and ready are high. The walker raises `req_ready` only while idle. Once `rsp_valid` is high, the response stays high and unchanged until `rsp_ready` is seen, so the requester may apply back-pressure for any number of cycles.

The memory request port is also valid/ready. `mem_req_valid` and the address, data and direction stay stable until `mem_req_ready` is high. A read returns exactly one `mem_rsp_valid` pulse with its data, some cycles after the accepting edge. The walker cannot stall this response. A write gets no response and counts as done at its accepting edge.

Top module: `page_walker`

## Requirements
- R1: The directory entry is read at `dir_base + 4*lin[31:22]`. The table entry is read at `{dir_entry[31:12], 12'h000} + 4*lin[21:12]`. A small page translates to `{table_entry[31:12], lin[11:0]}`.
- R2: When `paging_en` is 0 at the accepting edge, the response is a success with `rsp_phys` equal to the linear address. No memory request is issued.
- R3: An entry whose present flag (bit 0) is 0 ends the walk with `rsp_fault`=1 and `rsp_code[0]`=0 (not present). At the directory level, no table read follows.
- R4: Access rights are checked at each level, after the present check. A user access (`req_user`=1) to an entry whose bit 2 is 0 faults. A write access to an entry whose bit 1 is 0 also faults. Either case sets `rsp_code[0]`=1. In every fault, `rsp_code[1]` equals the write flag and `rsp_code[2]` equals the user flag.
- R5: A directory entry with bit 7 set, when `large_en` was 1 at acceptance, ends the walk after one read. It returns `{dir_entry[31:22], lin[21:0]}`. With `large_en`=0, bit 7 is ignored and a table walk follows.
- R6: Every entry that passes both the present and the rights checks gets its accessed flag (bit 5) set in memory. The walker never clears it. An entry is written back only when a flag actually changes.
- R7: A write access that passes the table-level checks sets the dirty flag (bit 6) of the table entry. Directory entries never get a dirty flag set. All write-backs are accepted before the response is raised.
- R8: On a fault, `fault_addr` takes the linear address of the faulting request. It keeps that value through later successful translations.
- R9: `req_ready` is high only while no translation is in flight. A response held by `rsp_ready`=0 stays valid and unchanged, and no new request is accepted during that time.
- R10: A memory request holds its valid, address, direction and data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| dir_base | input | 32 | Physical address of the directory, sampled at acceptance |
| paging_en | input | 1 | Translation enabled, sampled at acceptance |
| large_en | input | 1 | Large (4 MB) pages honoured, sampled at acceptance |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_phys | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Translation faulted |
| rsp_code | output | 3 | Fault cause: [0] rights violation, [1] write, [2] user |
| fault_addr | output | 32 | Linear address of the latest fault |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is an entry write-back |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Entry read from memory |

## Verification
Two functions can land on the same edge: the hold of a finished response under requester back-pressure, and the arrival of a fresh translation request. The bench creates this case on a regular slice of its sweep. It keeps `rsp_ready` low for several cycles while it drives `req_valid` with a different address. It then checks at each falling edge that `req_ready` stays low and that the response fields do not move, and it checks that the fresh request does not disturb the result that follows. A second overlap is the accessed/dirty write-back meeting memory back-pressure just before completion. The memory model's ready pattern causes this, and the bench judges it by comparing the entries in memory once the response appears.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ADDR_W  = 32;
  localparam int ENTRY_W = 32;

  // entry flag positions
  localparam int F_PRESENT  = 0;
  localparam int F_WRITABLE = 1;
  localparam int F_USER     = 2;
  localparam int F_ACCESSED = 5;
  localparam int F_DIRTY    = 6;
  localparam int F_LARGE    = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WAIT,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WAIT,
    ST_TBL_WB,
    ST_RESP
  } walk_state_e;

  typedef struct packed {
    logic user;
    logic write;
    logic prot;
  } fault_code_t;
endpackage

// File: rtl/pw_entry_eval.sv
module pw_entry_eval
  import pw_pkg::*;
#(
  parameter bit TABLE_LEVEL = 1'b0
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               write_i,
  input  logic               user_i,
  output logic               not_present_o,
  output logic               prot_fault_o,
  output logic [ENTRY_W-1:0] entry_upd_o,
  output logic               upd_needed_o
);
  logic [ENTRY_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[F_ACCESSED] = 1'b1;
    if (TABLE_LEVEL) set_mask[F_DIRTY] = write_i;
  end

  assign not_present_o = ~entry_i[F_PRESENT];
  assign prot_fault_o  = (user_i & ~entry_i[F_USER]) | (write_i & ~entry_i[F_WRITABLE]);
  assign entry_upd_o   = entry_i | set_mask;
  assign upd_needed_o  = (entry_upd_o != entry_i);
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
#(
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10
) (
  input  logic [ADDR_W-1:0]                     lin_i,
  input  logic [ADDR_W-1:0]                     dir_base_i,
  input  logic [ADDR_W-DIR_IDX_W-TBL_IDX_W-1+DIR_IDX_W+TBL_IDX_W:ADDR_W-DIR_IDX_W-TBL_IDX_W] dir_frame_i,
  input  logic [ADDR_W-1:ADDR_W-DIR_IDX_W-TBL_IDX_W] tbl_frame_i,
  output logic [ADDR_W-1:0]                     dir_ent_addr_o,
  output logic [ADDR_W-1:0]                     tbl_ent_addr_o,
  output logic [ADDR_W-1:0]                     large_phys_o,
  output logic [ADDR_W-1:0]                     small_phys_o
);
  localparam int OFF_W     = ADDR_W - DIR_IDX_W - TBL_IDX_W;
  localparam int LG_OFF_W  = TBL_IDX_W + OFF_W;
  localparam int ENT_SHIFT = $clog2(ENTRY_W / 8);

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;

  assign dir_idx = lin_i[ADDR_W-1 -: DIR_IDX_W];
  assign tbl_idx = lin_i[LG_OFF_W-1 -: TBL_IDX_W];

  assign dir_ent_addr_o = dir_base_i + (ADDR_W'(dir_idx) << ENT_SHIFT);
  assign tbl_ent_addr_o = {dir_frame_i, {OFF_W{1'b0}}} + (ADDR_W'(tbl_idx) << ENT_SHIFT);
  assign large_phys_o   = {dir_frame_i[ADDR_W-1 -: DIR_IDX_W], lin_i[LG_OFF_W-1:0]};
  assign small_phys_o   = {tbl_frame_i, lin_i[OFF_W-1:0]};
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin_addr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] dir_base,
  input  logic        paging_en,
  input  logic        large_en,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_phys,
  output logic        rsp_fault,
  output logic [2:0]  rsp_code,
  output logic [31:0] fault_addr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata
);
  localparam int OFF_W    = ADDR_W - DIR_IDX_W - TBL_IDX_W;
  localparam int N_LEVELS = 2;

  walk_state_e        state_q;
  logic [ADDR_W-1:0]  lin_q, base_q, dir_q, tbl_q, phys_q, fault_addr_q;
  logic               wr_q, usr_q, lg_q, fault_q;
  fault_code_t        code_q;

  logic [N_LEVELS-1:0]              lvl_np, lvl_prot, lvl_need;
  logic [N_LEVELS-1:0][ENTRY_W-1:0] lvl_upd;

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_level
    pw_entry_eval #(.TABLE_LEVEL(g == N_LEVELS - 1)) u_eval (
      .entry_i      (mem_rsp_rdata),
      .write_i      (wr_q),
      .user_i       (usr_q),
      .not_present_o(lvl_np[g]),
      .prot_fault_o (lvl_prot[g]),
      .entry_upd_o  (lvl_upd[g]),
      .upd_needed_o (lvl_need[g])
    );
  end

  logic [ADDR_W-1:0] dir_src, tbl_src;
  logic [ADDR_W-1:0] dir_ent_addr, tbl_ent_addr, large_phys, small_phys;

  assign dir_src = (state_q == ST_DIR_WAIT) ? mem_rsp_rdata : dir_q;
  assign tbl_src = (state_q == ST_TBL_WAIT) ? mem_rsp_rdata : tbl_q;

  pw_addr_gen #(.DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W)) u_addr (
    .lin_i         (lin_q),
    .dir_base_i    (base_q),
    .dir_frame_i   (dir_src[ADDR_W-1:OFF_W]),
    .tbl_frame_i   (tbl_src[ADDR_W-1:OFF_W]),
    .dir_ent_addr_o(dir_ent_addr),
    .tbl_ent_addr_o(tbl_ent_addr),
    .large_phys_o  (large_phys),
    .small_phys_o  (small_phys)
  );

  logic rd_large_hit, wb_large_hit;
  assign rd_large_hit = mem_rsp_rdata[F_LARGE] & lg_q;
  assign wb_large_hit = dir_q[F_LARGE] & lg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      lin_q        <= '0;
      base_q       <= '0;
      dir_q        <= '0;
      tbl_q        <= '0;
      phys_q       <= '0;
      fault_addr_q <= '0;
      wr_q         <= 1'b0;
      usr_q        <= 1'b0;
      lg_q         <= 1'b0;
      fault_q      <= 1'b0;
      code_q       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            lin_q   <= req_lin_addr;
            base_q  <= dir_base;
            wr_q    <= req_write;
            usr_q   <= req_user;
            lg_q    <= large_en;
            fault_q <= 1'b0;
            code_q  <= '0;
            if (paging_en) begin
              state_q <= ST_DIR_RD;
            end else begin
              phys_q  <= req_lin_addr;
              state_q <= ST_RESP;
            end
          end
        end
        ST_DIR_RD: if (mem_req_ready) state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: begin
          if (mem_rsp_valid) begin
            if (lvl_np[0] || lvl_prot[0]) begin
              fault_q      <= 1'b1;
              code_q       <= '{user: usr_q, write: wr_q, prot: ~lvl_np[0]};
              fault_addr_q <= lin_q;
              phys_q       <= '0;
              state_q      <= ST_RESP;
            end else begin
              dir_q <= lvl_upd[0];
              if (lvl_need[0]) begin
                state_q <= ST_DIR_WB;
              end else if (rd_large_hit) begin
                phys_q  <= large_phys;
                state_q <= ST_RESP;
              end else begin
                state_q <= ST_TBL_RD;
              end
            end
          end
        end
        ST_DIR_WB: begin
          if (mem_req_ready) begin
            if (wb_large_hit) begin
              phys_q  <= large_phys;
              state_q <= ST_RESP;
            end else begin
              state_q <= ST_TBL_RD;
            end
          end
        end
        ST_TBL_RD: if (mem_req_ready) state_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: begin
          if (mem_rsp_valid) begin
            if (lvl_np[1] || lvl_prot[1]) begin
              fault_q      <= 1'b1;
              code_q       <= '{user: usr_q, write: wr_q, prot: ~lvl_np[1]};
              fault_addr_q <= lin_q;
              phys_q       <= '0;
              state_q      <= ST_RESP;
            end else begin
              tbl_q <= lvl_upd[1];
              if (lvl_need[1]) begin
                state_q <= ST_TBL_WB;
              end else begin
                phys_q  <= small_phys;
                state_q <= ST_RESP;
              end
            end
          end
        end
        ST_TBL_WB: begin
          if (mem_req_ready) begin
            phys_q  <= small_phys;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic in_dir_phase;
  assign in_dir_phase = (state_q == ST_DIR_RD) || (state_q == ST_DIR_WB);

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_phys      = phys_q;
  assign rsp_fault     = fault_q;
  assign rsp_code      = code_q;
  assign fault_addr    = fault_addr_q;
  assign mem_req_valid = in_dir_phase || (state_q == ST_TBL_RD) || (state_q == ST_TBL_WB);
  assign mem_req_write = (state_q == ST_DIR_WB) || (state_q == ST_TBL_WB);
  assign mem_req_addr  = in_dir_phase ? dir_ent_addr : tbl_ent_addr;
  assign mem_req_wdata = (state_q == ST_DIR_WB) ? dir_q : tbl_q;
endmodule

// File: rtl/pw_checker.sv
module pw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_lin_addr,
  input logic        req_write,
  input logic        req_user,
  input logic        paging_en,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_phys,
  input logic        rsp_fault,
  input logic [2:0]  rsp_code,
  input logic [31:0] fault_addr,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata
);
  logic [31:0] lin_c;
  logic        wr_c, usr_c, pg_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_c <= '0;
      wr_c  <= 1'b0;
      usr_c <= 1'b0;
      pg_c  <= 1'b1;
    end else if (req_valid && req_ready) begin
      lin_c <= req_lin_addr;
      wr_c  <= req_write;
      usr_c <= req_user;
      pg_c  <= paging_en;
    end
  end

  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_phys) && $stable(rsp_fault) && $stable(rsp_code))); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata))); // R10
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[5]); // R6
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (fault_addr == lin_c)); // R8
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_code[1] == wr_c && rsp_code[2] == usr_c)); // R4
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !pg_c) |-> (!rsp_fault && rsp_phys == lin_c)); // R2
  AST_PASS_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_c && !req_ready) |-> !mem_req_valid); // R2
endmodule

bind page_walker pw_checker u_pw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_lin_addr (req_lin_addr),
  .req_write    (req_write),
  .req_user     (req_user),
  .paging_en    (paging_en),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_phys     (rsp_phys),
  .rsp_fault    (rsp_fault),
  .rsp_code     (rsp_code),
  .fault_addr   (fault_addr),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/page_walker_test.sv
module page_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DIR_BASE  = 32'h0000_1000;
  localparam logic [19:0] TBL_FRAME = 20'hA5402;
  localparam logic [19:0] PG_FRAME  = 20'h12345;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_lin_addr = '0;
  logic        paging_en = 1'b1, large_en = 1'b0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
  logic [31:0] rsp_phys, fault_addr;
  logic [2:0]  rsp_code;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  page_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin_addr(req_lin_addr),
    .req_write(req_write), .req_user(req_user), .dir_base(DIR_BASE),
    .paging_en(paging_en), .large_en(large_en),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_phys(rsp_phys),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code), .fault_addr(fault_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memory model: word index from address bits [13:2]
  logic [31:0] mem [0:4095];
  logic        poke_en = 1'b0;
  logic [11:0] poke_idx = '0;
  logic [31:0] poke_data = '0;
  int          rd_cnt, wr_cnt, stall_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      mem_req_ready <= 1'b0;
      rd_cnt <= 0; wr_cnt <= 0; stall_cnt <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      stall_cnt     <= stall_cnt + 1;
      mem_req_ready <= ((stall_cnt % 5) != 1) && ((stall_cnt % 7) != 3);
      if (poke_en) mem[poke_idx] <= poke_data;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr[13:2]] <= mem_req_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem[mem_req_addr[13:2]];
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] idx, input logic [31:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = idx; poke_data = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // one translation; hold>0 keeps rsp_ready low and presents a stray request
  task automatic translate(input logic [31:0] lin, input logic w, input logic u,
                           input logic pg, input logic lg, input int hold,
                           output logic [31:0] phys, output logic flt,
                           output logic [2:0] code);
    logic [31:0] p0;
    logic        f0;
    logic [2:0]  c0;
    @(negedge clk);
    req_lin_addr = lin; req_write = w; req_user = u;
    paging_en = pg; large_en = lg; req_valid = 1'b1; rsp_ready = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    if (hold > 0) begin
      p0 = rsp_phys; f0 = rsp_fault; c0 = rsp_code;
      req_lin_addr = ~lin; req_valid = 1'b1;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk("R9 ready low under held response", {31'b0, req_ready}, 32'd0);
        chk("R9 response held", {rsp_valid, rsp_fault, rsp_code, 27'b0}, {1'b1, f0, c0, 27'b0});
        chk("R9 phys held", rsp_phys, p0);
      end
      req_valid = 1'b0; req_lin_addr = lin;
    end
    phys = rsp_phys; flt = rsp_fault; code = rsp_code;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] phys, lin, dent, tent, fa_prev, exp_phys;
    logic        flt, e_flt, dir_ok, reach_tbl, tbl_ok, e_prot;
    logic [2:0]  code;
    logic [9:0]  d, t;
    logic [11:0] off;
    logic        dP, dRW, dUS, dPS, dA, tP, tRW, tUS, tA, tD, w, u, lg;
    int          rd0, wr0, e_rd, e_wr;

    repeat (3) @(negedge clk);
    chk("R9 reset req_ready", {31'b0, req_ready}, 32'd1);
    chk("R9 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R10 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    chk("R8 reset fault_addr", fault_addr, 32'd0);
    rst_n = 1'b1;
    fa_prev = '0;

    // R2: pass-through with paging off, no memory traffic
    for (int i = 0; i < 8; i++) begin
      lin = 32'h9E37_79B9 * (i + 1);
      rd0 = rd_cnt; wr0 = wr_cnt;
      translate(lin, i[0], i[1], 1'b0, i[2], 0, phys, flt, code);
      chk("R2 passthrough phys", phys, lin);
      chk("R2 passthrough no fault", {31'b0, flt}, 32'd0);
      chk("R2 no memory requests", rd_cnt + wr_cnt - rd0 - wr0, 32'd0);
    end

    // R1 R3 R4 R5 R6 R7 R8: sweep of entry flags and access types
    for (int i = 0; i < 4096; i++) begin
      dP = i[0]; dRW = i[1]; dUS = i[2]; dPS = i[3];
      tP = i[4]; tRW = i[5]; tUS = i[6];
      w  = i[7]; u = i[8]; lg = i[9]; tA = i[10]; tD = i[11];
      dA = i[2] ^ i[9] ^ i[10];
      d   = 10'((i * 37 + 5) % 1024);
      t   = 10'((i * 53 + 11) % 1024);
      off = 12'((i * 97) % 4096);
      lin = {d, t, off};
      dent = {TBL_FRAME, 4'b0, dPS, 1'b0, dA, 2'b00, dUS, dRW, dP};
      tent = {PG_FRAME, 3'b0, 1'b0, 1'b0, tD, tA, 2'b00, tUS, tRW, tP};
      poke(12'(1024 + d), dent);
      poke(12'(2048 + t), tent);

      dir_ok    = dP && !(u && !dUS) && !(w && !dRW);
      reach_tbl = dir_ok && !(dPS && lg);
      tbl_ok    = reach_tbl && tP && !(u && !tUS) && !(w && !tRW);
      if (!dir_ok) begin
        e_flt = 1'b1; e_prot = dP;
      end else if (reach_tbl && !tbl_ok) begin
        e_flt = 1'b1; e_prot = tP;
      end else begin
        e_flt = 1'b0; e_prot = 1'b0;
      end
      exp_phys = e_flt ? 32'd0 : (reach_tbl ? {PG_FRAME, off} : {TBL_FRAME[19:10], t, off});
      e_rd = 1 + (reach_tbl ? 1 : 0);
      e_wr = ((dir_ok && !dA) ? 1 : 0) + ((tbl_ok && (!tA || (w && !tD))) ? 1 : 0);

      rd0 = rd_cnt; wr0 = wr_cnt;
      translate(lin, w, u, 1'b1, lg, ((i % 32) == 0) ? 3 : 0, phys, flt, code);

      chk("R3 R4 fault flag", {31'b0, flt}, {31'b0, e_flt});
      if (e_flt) begin
        chk("R3 R4 fault code", {29'b0, code}, {29'b0, u, w, e_prot});
        chk("R8 fault_addr latched", fault_addr, lin);
        fa_prev = lin;
      end else begin
        chk("R1 R5 physical address", phys, exp_phys);
        chk("R8 fault_addr kept", fault_addr, fa_prev);
      end
      chk("R1 R5 read count", rd_cnt - rd0, e_rd);
      chk("R6 R7 write-back count", wr_cnt - wr0, e_wr);
      chk("R6 directory entry in memory", mem[12'(1024 + d)], dir_ok ? (dent | 32'h20) : dent);
      chk("R6 R7 table entry in memory", mem[12'(2048 + t)],
          tbl_ok ? (tent | 32'h20 | (w ? 32'h40 : 32'h0)) : tent);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule